// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Adder

This block adds two signed two's complement fixed-point numbers whose binary points sit in different places. Operand A carries `A_INT` integer bits (sign included) and `A_FRAC` fraction bits. Operand B carries `B_INT` and `B_FRAC`. Before the add, each operand is brought to a common grid. Zeros are appended below the operand with the shorter fraction. The sign bit is replicated above the operand with the shorter integer part. The two aligned words are then added modulo 2^W.

The result has the larger of the two fraction widths. Its integer width is the larger of the two integer widths, plus one when `EXTRA_INT_BIT` is 1. In the narrow result, a flag reports a sum that does not fit. The wide result can always hold the sum, so its flag stays low. The output is either a register stage with a valid pulse and one cycle of latency, or a purely combinational path; the parameter `REGISTERED` selects which.

Top module: `qmix_adder`

## Requirements
- R1: The sum is `max(A_INT,B_INT)+EXTRA_INT_BIT` integer bits above `max(A_FRAC,B_FRAC)` fraction bits. With the defaults (A as 2.2, B as 3.3), `sum_out` is 6 bits with 3 fraction bits.
- R2: The operand with fewer fraction bits is shifted up by the difference, with zeros in the new low bits, so its value is kept. With the defaults, a = 4'b0001 (+0.25) plus b = 0 gives 6'b000010.
- R3: The operand with fewer integer bits is sign-extended, never zero-extended. a = 4'b1011 (-1.25) plus b = 0 gives 6'b110110, and a = 4'b1000 (-2) plus b = 6'b000001 gives 6'b110001.
- R4: The aligned words are added modulo 2^W, and any carry above the result's sign bit is dropped. a = 4'b1011 (-1.25) plus b = 6'b011010 (+3.25) gives 6'b010000 (+2) with `ovf_out` = 0.
- R5: With `EXTRA_INT_BIT` = 0, `ovf_out` is 1 exactly when the true sum falls outside the result's range, which is when both operands share a sign and the sum's sign bit differs. -1.25 + -3.875 gives 6'b010111 with `ovf_out` = 1, and +1.75 + +3.875 gives 6'b101101 with `ovf_out` = 1.
- R6: Sums at the edges of the range raise no flag. -1 + -3 gives 6'b100000 (-4), and +1.75 + +2.125 gives 6'b011111 (+3.875), both with `ovf_out` = 0.
- R7: With `EXTRA_INT_BIT` = 1, the result is one integer bit wider and `ovf_out` is always 0. -1.25 + -3.875 gives 7'b1010111 (-5.125).
- R8: With `REGISTERED` = 1, `out_valid` follows `in_valid` one clock later and the sum and flag appear in that cycle. A cycle with `in_valid` = 0 leaves `sum_out` and `ovf_out` unchanged.
- R9: With `REGISTERED` = 1, a synchronous active-high `rst` clears `out_valid`, `sum_out` and `ovf_out` at the next clock edge. Reset takes priority over `in_valid`.
- R10: With `REGISTERED` = 0, `out_valid` equals `in_valid`, and the sum and flag follow the operands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a_in | input | A_INT+A_FRAC | Operand A, two's complement |
| b_in | input | B_INT+B_FRAC | Operand B, two's complement |
| out_valid | output | 1 | Result is valid |
| sum_out | output | R_INT+R_FRAC | Aligned sum |
| ovf_out | output | 1 | Sum did not fit the result format |

## Verification
A fault in the aligners shows up on `sum_out` as soon as the affected result comes out. A missing sign extension shows on every negative A. A wrong fraction shift shows as a sum scaled by a power of two. These faults appear after one clock in the registered build and in the same cycle in the combinational one. A wrong overflow rule shows in `ovf_out` on the first sign-matched pair that wraps, or on the first pair that lands exactly on a range edge. A fault in the valid or hold register shows as an unexpected or missing result pulse, or as a sum that drifts while `in_valid` is low. The bench drives every pair of operand values through both variants, so each of these faults shows up within the first pass of that sweep.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
   function automatic int qmax(input int x, input int y);
      return (x > y) ? x : y;
   endfunction
endpackage

// File: rtl/qmix_align.sv
module qmix_align #(
   parameter int IN_INT   = 2,
   parameter int IN_FRAC  = 2,
   parameter int OUT_INT  = 3,
   parameter int OUT_FRAC = 3,
   localparam int IN_W    = IN_INT + IN_FRAC,
   localparam int OUT_W   = OUT_INT + OUT_FRAC
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int INT_PAD  = OUT_INT - IN_INT;
   localparam int FRAC_PAD = OUT_FRAC - IN_FRAC;
   localparam int EXT_W    = IN_W + INT_PAD;

   if (INT_PAD < 0) begin : g_bad_int
      $error("qmix_align: output integer part narrower than input");
   end
   if (FRAC_PAD < 0) begin : g_bad_frac
      $error("qmix_align: output fraction narrower than input");
   end

   logic [EXT_W-1:0] ext;

   if (INT_PAD > 0) begin : g_sext
      assign ext = {{INT_PAD{din[IN_W-1]}}, din};
   end else begin : g_no_sext
      assign ext = din;
   end

   if (FRAC_PAD > 0) begin : g_pad
      assign dout = {ext, {FRAC_PAD{1'b0}}};
   end else begin : g_no_pad
      assign dout = ext;
   end
endmodule

// File: rtl/qmix_add_core.sv
module qmix_add_core #(
   parameter int W       = 6,
   parameter bit NO_OVF  = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         ovf
);
   if (W < 2) begin : g_bad_w
      $error("qmix_add_core: width must be at least 2");
   end

   assign sum = a + b;

   if (NO_OVF) begin : g_wide
      assign ovf = 1'b0;
   end else begin : g_flag
      logic same_sign;
      assign same_sign = ~(a[W-1] ^ b[W-1]);
      assign ovf       = same_sign & (sum[W-1] ^ a[W-1]);
   end
endmodule

// File: rtl/qmix_out_stage.sv
module qmix_out_stage #(
   parameter int W          = 6,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] sum_d,
   input  logic         ovf_d,
   output logic         out_valid,
   output logic [W-1:0] sum_q,
   output logic         ovf_q
);
   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            out_valid <= 1'b0;
            sum_q     <= '0;
            ovf_q     <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               sum_q <= sum_d;
               ovf_q <= ovf_d;
            end
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign sum_q     = sum_d;
      assign ovf_q     = ovf_d;
   end
endmodule

// File: rtl/qmix_adder.sv
module qmix_adder #(
   parameter int A_INT         = 2,
   parameter int A_FRAC        = 2,
   parameter int B_INT         = 3,
   parameter int B_FRAC        = 3,
   parameter bit EXTRA_INT_BIT = 1'b0,
   parameter bit REGISTERED    = 1'b1,
   localparam int A_W    = A_INT + A_FRAC,
   localparam int B_W    = B_INT + B_FRAC,
   localparam int R_INT  = qmix_pkg::qmax(A_INT, B_INT) + int'(EXTRA_INT_BIT),
   localparam int R_FRAC = qmix_pkg::qmax(A_FRAC, B_FRAC),
   localparam int R_W    = R_INT + R_FRAC
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   output logic           out_valid,
   output logic [R_W-1:0] sum_out,
   output logic           ovf_out
);
   if (A_INT < 1 || B_INT < 1) begin : g_bad_int
      $error("qmix_adder: each operand needs a sign bit");
   end
   if (A_FRAC < 0 || B_FRAC < 0) begin : g_bad_frac
      $error("qmix_adder: fraction widths must be non-negative");
   end

   logic [R_W-1:0] a_al;
   logic [R_W-1:0] b_al;
   logic [R_W-1:0] sum_c;
   logic           ovf_c;

   qmix_align #(
      .IN_INT  (A_INT),
      .IN_FRAC (A_FRAC),
      .OUT_INT (R_INT),
      .OUT_FRAC(R_FRAC)
   ) u_align_a (
      .din (a_in),
      .dout(a_al)
   );

   qmix_align #(
      .IN_INT  (B_INT),
      .IN_FRAC (B_FRAC),
      .OUT_INT (R_INT),
      .OUT_FRAC(R_FRAC)
   ) u_align_b (
      .din (b_in),
      .dout(b_al)
   );

   qmix_add_core #(
      .W     (R_W),
      .NO_OVF(EXTRA_INT_BIT)
   ) u_core (
      .a  (a_al),
      .b  (b_al),
      .sum(sum_c),
      .ovf(ovf_c)
   );

   qmix_out_stage #(
      .W         (R_W),
      .REGISTERED(REGISTERED)
   ) u_out (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .sum_d    (sum_c),
      .ovf_d    (ovf_c),
      .out_valid(out_valid),
      .sum_q    (sum_out),
      .ovf_q    (ovf_out)
   );
endmodule

// File: rtl/qmix_adder_chk.sv
module qmix_adder_chk #(
   parameter int A_W        = 4,
   parameter int B_W        = 6,
   parameter int R_W        = 6,
   parameter bit EXTRA      = 1'b0,
   parameter bit REGISTERED = 1'b1
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic [A_W-1:0] a_in,
   input logic [B_W-1:0] b_in,
   input logic           out_valid,
   input logic [R_W-1:0] sum_out,
   input logic           ovf_out
);
   if (REGISTERED) begin : g_reg_chk
      assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
         $past(rst) |-> (!out_valid && sum_out == '0 && !ovf_out));

      assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> (out_valid == $past(in_valid)));

      assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !$past(in_valid)) |-> ($stable(sum_out) && $stable(ovf_out)));

      assert_ovf_sign_R5: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && out_valid && ovf_out) |->
            (($past(a_in[A_W-1]) == $past(b_in[B_W-1])) &&
             (sum_out[R_W-1] != $past(a_in[A_W-1]))));

      if (EXTRA) begin : g_wide_reg
         assert_no_ovf_R7: assert property (@(posedge clk) disable iff (rst)
            !ovf_out);
      end
   end else begin : g_comb_chk
      always @(posedge clk) begin
         if (!rst) begin
            assert_passthru_R10: assert (out_valid == in_valid);
            if (EXTRA) begin
               assert_no_ovf_R7: assert (!ovf_out);
            end
         end
      end
   end
endmodule

bind qmix_adder qmix_adder_chk #(
   .A_W       (A_W),
   .B_W       (B_W),
   .R_W       (R_W),
   .EXTRA     (EXTRA_INT_BIT),
   .REGISTERED(REGISTERED)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .a_in     (a_in),
   .b_in     (b_in),
   .out_valid(out_valid),
   .sum_out  (sum_out),
   .ovf_out  (ovf_out)
);

// File: tb/qmix_adder_bench.sv
module qmix_adder_bench;
   localparam int PERIOD = 10;
   localparam int AI = 2, AF = 2, BI = 3, BF = 3;
   localparam int AW = AI + AF, BW = BI + BF;
   localparam int RF = 3;
   localparam int RW = 6;
   localparam int WW = 7;

   typedef struct {
      logic [RW-1:0] sum;
      logic          ovf;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          vin = 1'b0;
   logic [AW-1:0] a   = '0;
   logic [BW-1:0] b   = '0;
   logic          ov_n, of_n, ov_w, of_w;
   logic [RW-1:0] s_n;
   logic [WW-1:0] s_w;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   exp_t q[$];
   exp_t last_e;

   always #(PERIOD/2) clk = ~clk;

   qmix_adder u_qmix_adder (
      .clk(clk), .rst(rst), .in_valid(vin), .a_in(a), .b_in(b),
      .out_valid(ov_n), .sum_out(s_n), .ovf_out(of_n)
   );

   qmix_adder #(.EXTRA_INT_BIT(1'b1), .REGISTERED(1'b0)) u_wide (
      .clk(clk), .rst(rst), .in_valid(vin), .a_in(a), .b_in(b),
      .out_valid(ov_w), .sum_out(s_w), .ovf_out(of_w)
   );

   function automatic longint true_sum(input logic [AW-1:0] av, input logic [BW-1:0] bv);
      longint sa, sb;
      sa = longint'($signed(av)) * (longint'(1) << (RF - AF));
      sb = longint'($signed(bv)) * (longint'(1) << (RF - BF));
      return sa + sb;
   endfunction

   task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [AW-1:0] av, input logic [BW-1:0] bv, input string tag);
      longint s;
      exp_t   e;
      logic [WW-1:0] ew;
      @(negedge clk);
      a   = av;
      b   = bv;
      vin = 1'b1;
      s   = true_sum(av, bv);
      e.sum = RW'(s);
      e.ovf = (s > 31) || (s < -32);
      e.tag = tag;
      q.push_back(e);
      last_e = e;
      ew = WW'(s);
      #1;
      check({tag, " wide sum (R7)"}, s_w, ew);
      check("R7 wide flag low", {6'b0, of_w}, '0);
      check("R10 comb valid", {6'b0, ov_w}, {6'b0, vin});
   endtask

   always @(negedge clk) begin
      if (!rst && ov_n) begin
         if (q.size() == 0) begin
            check("R8 unexpected out_valid", 7'd1, 7'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " sum"}, {1'b0, s_n}, {1'b0, e.sum});
            check({e.tag, " ovf"}, {6'b0, of_n}, {6'b0, e.ovf});
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset valid", {6'b0, ov_n}, '0);
      check("R9 reset sum", {1'b0, s_n}, '0);
      check("R9 reset ovf", {6'b0, of_n}, '0);
      @(negedge clk);
      rst = 1'b0;

      drive(4'b1011, 6'b011010, "R4 -1.25+3.25");
      drive(4'b1011, 6'b100001, "R5 neg wrap");
      drive(4'b0111, 6'b011111, "R5 pos wrap");
      drive(4'b1100, 6'b101000, "R6 low edge");
      drive(4'b0111, 6'b010001, "R6 high edge");
      drive(4'b0001, 6'b000000, "R2 frac pad");
      drive(4'b1011, 6'b000000, "R3 sext");
      drive(4'b1000, 6'b000001, "R3 min a");
      drive(4'b0000, 6'b100000, "R1 width min b");
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 64; j++) begin
            drive(AW'(i), BW'(j), "R4 sweep");
         end
      end

      @(negedge clk);
      vin = 1'b0;
      a   = 4'b0101;
      b   = 6'b010101;
      @(negedge clk);
      check("R8 idle valid", {6'b0, ov_n}, '0);
      check("R8 hold sum", {1'b0, s_n}, {1'b0, last_e.sum});
      check("R8 hold ovf", {6'b0, of_n}, {6'b0, last_e.ovf});
      check("R8 queue drained", WW'(q.size()), '0);

      vin = 1'b1;
      a   = 4'b0111;
      b   = 6'b001111;
      rst = 1'b1;
      @(negedge clk);
      check("R9 reset beats valid", {6'b0, ov_n}, '0);
      check("R9 reset clears sum", {1'b0, s_n}, '0);
      check("R9 reset clears ovf", {6'b0, of_n}, '0);
      vin = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule